// File: doc/BRIEF.md
# Multi-Lane Frame Deskew Buffer

This block takes a set of independent serial bit lanes, each already recovered into a bit stream with its own valid strobe, and rebuilds complete parallel frames of 12 unit intervals per lane. The lanes may arrive with up to 46 unit intervals of skew between them. Each lane writes into its own circular buffer. A training pass finds the frame boundary on each lane from a per-lane marker that is asserted with the first bit of a frame. The block emits one aligned frame as soon as the slowest lane has delivered all 12 bits of that frame.

A mode input selects between two behaviours. In resync mode, frames are held until every lane is complete and are then driven out together on a wide bus. In resample mode, each lane is forwarded on its own, one register stage later, with no alignment between lanes, and the frame bus stays quiet.

The controller has four states:
- `ST_IDLE`: the state after reset. `train_req` moves it to `ST_TRAIN`.
- `ST_TRAIN`: the lanes collect their markers. From here:
  - when every lane has its marker and the spread is within bounds, it moves to `ST_RUN`;
  - when more than 46 cycles pass after the first marker, it moves to `ST_ERR`.
- `ST_RUN`: frames are emitted. `train_req` moves it back to `ST_TRAIN`.
- `ST_ERR`: the error state. It holds until `train_req` moves it to `ST_TRAIN`.

Top module: `lane_deskew`

## Requirements
- R1: After reset, `frm_valid`, `align_err` and `pass_vld` are all low, and the controller is in `ST_IDLE`.
- R2: A one-cycle `train_req` starts training. A lane's marker is taken only in `ST_TRAIN`, and only the first one per lane counts. The bit that carries the marker becomes bit 0 of that lane's slice of the first frame. Markers seen in `ST_RUN` have no effect on alignment.
- R3: In resync mode, each emitted frame carries lane L in `frm_data[12L+11:12L]`, with bit 12L holding the earliest unit interval of that lane's frame.
- R4: `frm_valid` is a one-cycle pulse. It rises on the clock edge that follows the edge that captured the 12th bit of the slowest lane.
- R5: A skew of exactly 46 cycles between the first and the last lane marker is accepted. Frames are then produced normally.
- R6: A marker skew of 47 cycles or more raises `align_err`, and no frame is emitted.
- R7: `align_err` stays high until `train_req`. A new training pass with good skew clears it, and frames resume.
- R8: In resample mode (`mode_resync`=0), `frm_valid` stays low.
- R9: In resample mode, `pass_vld` and `pass_bit` equal `lane_vld` and `lane_bit` of the previous edge. In resync mode, `pass_vld` is zero.
- R10: Successive frames come out in arrival order, with none lost or repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one unit interval per valid strobe |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_resync | input | 1 | 1 = aligned frame output, 0 = per-lane pass-through |
| train_req | input | 1 | One-cycle pulse that starts a training pass |
| lane_bit | input | LANES | Recovered data bit per lane |
| lane_vld | input | LANES | Per-lane valid strobe |
| lane_mark | input | LANES | Per-lane frame-start marker, given with the first bit of a frame |
| frm_valid | output | 1 | Aligned frame present on `frm_data` |
| frm_data | output | LANES*12 | Aligned frame, 12 bits per lane |
| align_err | output | 1 | Measured skew exceeded the limit |
| pass_bit | output | LANES | Registered lane bits (resample mode) |
| pass_vld | output | LANES | Registered lane strobes (resample mode) |

## Verification
The only results with a fixed delay are the following:
- A pass-through bit appears one edge after the edge that samples it.
- A frame appears one edge after the edge that captures the slowest lane's last bit of that frame.

The driver knows each lane's skew and the start edge. From these it computes the due edge of every frame as start + maximum skew + 12k + 12, and it queues that edge together with the expected data. A shared edge counter drives the monitor. The monitor samples 5 ns after each rising edge and compares both the contents and the edge number of each popped frame. It checks the pass-through outputs against the inputs held for that same edge. Any frame that arrives while the queue is empty is reported as a failure.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_RUN   = 2'd2,
        ST_ERR   = 2'd3
    } dsk_state_e;
endpackage

// File: rtl/dsk_lane_buf.sv
module dsk_lane_buf #(
    parameter int DEPTH    = 64,
    parameter int FRAME_UI = 12,
    localparam int PW      = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_in,
    input  logic                vld_in,
    input  logic                cap,
    input  logic                adv,
    output logic [PW:0]         fill,
    output logic [FRAME_UI-1:0] frame_bits
);
    logic [DEPTH-1:0] mem_q;
    logic [PW:0]      wr_q;
    logic [PW:0]      rd_q;

    always_ff @(posedge clk) begin
        if (vld_in) mem_q[wr_q[PW-1:0]] <= bit_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q <= '0;
            rd_q <= '0;
        end else begin
            if (vld_in) wr_q <= wr_q + 1'b1;
            // frame start on this lane is the slot being written now
            if (cap)      rd_q <= wr_q;
            else if (adv) rd_q <= rd_q + (PW+1)'(FRAME_UI);
        end
    end

    assign fill = wr_q - rd_q;

    always_comb begin
        for (int i = 0; i < FRAME_UI; i++) begin
            frame_bits[i] = mem_q[rd_q[PW-1:0] + PW'(i)];
        end
    end
endmodule

// File: rtl/dsk_train_ctrl.sv
module dsk_train_ctrl
    import lane_deskew_pkg::*;
#(
    parameter int LANES    = 10,
    parameter int MAX_SKEW = 46,
    localparam int CW      = $clog2(MAX_SKEW + 2) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             train_req,
    input  logic [LANES-1:0] lane_vld,
    input  logic [LANES-1:0] lane_mark,
    input  logic             all_ready,
    output dsk_state_e       state,
    output logic [LANES-1:0] cap,
    output logic             adv,
    output logic             align_err
);
    dsk_state_e       state_q, state_d;
    logic [LANES-1:0] seen_q, seen_d, hit;
    logic [CW-1:0]    skew_q;
    logic             enter_train;

    assign hit         = lane_vld & lane_mark & ~seen_q & {LANES{state_q == ST_TRAIN}};
    assign seen_d      = seen_q | hit;
    assign enter_train = (state_d == ST_TRAIN) && (state_q != ST_TRAIN);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (train_req) state_d = ST_TRAIN;
            ST_TRAIN: begin
                if (skew_q > CW'(MAX_SKEW)) state_d = ST_ERR;
                else if (&seen_d)           state_d = ST_RUN;
            end
            ST_RUN:   if (train_req) state_d = ST_TRAIN;
            ST_ERR:   if (train_req) state_d = ST_TRAIN;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and training bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            seen_q  <= '0;
            skew_q  <= '0;
        end else begin
            state_q <= state_d;
            if (enter_train) begin
                seen_q <= '0;
                skew_q <= '0;
            end else if (state_q == ST_TRAIN) begin
                seen_q <= seen_d;
                if ((|seen_d) && (skew_q <= CW'(MAX_SKEW))) skew_q <= skew_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        state     = state_q;
        cap       = hit;
        adv       = (state_q == ST_RUN) && all_ready;
        align_err = (state_q == ST_ERR);
    end
endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
    import lane_deskew_pkg::*;
#(
    parameter int LANES    = 10,
    parameter int FRAME_UI = 12,
    parameter int DEPTH    = 64,
    parameter int MAX_SKEW = 46,
    localparam int PW      = $clog2(DEPTH),
    localparam int FW      = LANES * FRAME_UI
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_resync,
    input  logic             train_req,
    input  logic [LANES-1:0] lane_bit,
    input  logic [LANES-1:0] lane_vld,
    input  logic [LANES-1:0] lane_mark,
    output logic             frm_valid,
    output logic [FW-1:0]    frm_data,
    output logic             align_err,
    output logic [LANES-1:0] pass_bit,
    output logic [LANES-1:0] pass_vld
);
    dsk_state_e          state;
    logic [LANES-1:0]    cap;
    logic                adv;
    logic [LANES-1:0]    lane_full;
    logic [PW:0]         fill  [LANES];
    logic [FRAME_UI-1:0] fbits [LANES];
    logic [FW-1:0]       frame_w;

    dsk_train_ctrl #(.LANES(LANES), .MAX_SKEW(MAX_SKEW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .train_req (train_req),
        .lane_vld  (lane_vld),
        .lane_mark (lane_mark),
        .all_ready (&lane_full),
        .state     (state),
        .cap       (cap),
        .adv       (adv),
        .align_err (align_err)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dsk_lane_buf #(.DEPTH(DEPTH), .FRAME_UI(FRAME_UI)) u_buf (
            .clk        (clk),
            .rst_n      (rst_n),
            .bit_in     (lane_bit[g]),
            .vld_in     (lane_vld[g]),
            .cap        (cap[g]),
            .adv        (adv),
            .fill       (fill[g]),
            .frame_bits (fbits[g])
        );
        assign lane_full[g]                    = fill[g] >= (PW+1)'(FRAME_UI);
        assign frame_w[g*FRAME_UI +: FRAME_UI] = fbits[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_valid <= 1'b0;
            frm_data  <= '0;
            pass_bit  <= '0;
            pass_vld  <= '0;
        end else begin
            frm_valid <= adv && mode_resync;
            if (adv) frm_data <= frame_w;
            pass_bit  <= lane_bit;
            pass_vld  <= lane_vld & {LANES{~mode_resync}};
        end
    end
endmodule

// File: rtl/lane_deskew_chk.sv
module lane_deskew_chk #(
    parameter int LANES = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode_resync,
    input logic             train_req,
    input logic [LANES-1:0] lane_vld,
    input logic             frm_valid,
    input logic             align_err,
    input logic [LANES-1:0] pass_vld
);
    // R6: an alignment error never coexists with a frame
    a_r6_err_blocks_frame: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> !frm_valid);

    // R7: error is held until a training request
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (align_err && !train_req) |=> align_err);

    // R8: frames only follow an edge in resync mode
    a_r8_resample_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
        frm_valid |-> $past(mode_resync));

    // R9: pass-through strobes follow the inputs in resample mode
    a_r9_pass_follow: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_resync) |-> (pass_vld == $past(lane_vld)));

    // R9: pass-through strobes are quiet in resync mode
    a_r9_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mode_resync) |-> (pass_vld == '0));
endmodule

bind lane_deskew lane_deskew_chk #(.LANES(LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_resync (mode_resync),
    .train_req   (train_req),
    .lane_vld    (lane_vld),
    .frm_valid   (frm_valid),
    .align_err   (align_err),
    .pass_vld    (pass_vld)
);

// File: tb/lane_deskew_bench.sv
module lane_deskew_bench;
    localparam int LANES = 10;
    localparam int FUI   = 12;
    localparam int FW    = LANES * FUI;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode_resync = 1'b1;
    logic             train_req = 1'b0;
    logic [LANES-1:0] lane_bit = '0;
    logic [LANES-1:0] lane_vld = '0;
    logic [LANES-1:0] lane_mark = '0;
    logic             frm_valid;
    logic [FW-1:0]    frm_data;
    logic             align_err;
    logic [LANES-1:0] pass_bit;
    logic [LANES-1:0] pass_vld;

    typedef struct {
        logic [FW-1:0] data;
        int            due;
    } item_t;

    item_t q[$];
    int    n_chk = 0;
    int    n_fail = 0;
    int    edge_no = 0;
    int    sk[LANES];
    bit    done = 1'b0;

    always #10 clk = ~clk;

    lane_deskew u_lane_deskew (
        .clk(clk), .rst_n(rst_n), .mode_resync(mode_resync), .train_req(train_req),
        .lane_bit(lane_bit), .lane_vld(lane_vld), .lane_mark(lane_mark),
        .frm_valid(frm_valid), .frm_data(frm_data), .align_err(align_err),
        .pass_bit(pass_bit), .pass_vld(pass_vld)
    );

    always @(posedge clk) edge_no <= edge_no + 1;

    task automatic chk(input bit ok, input string msg);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s", msg);
        end
    endtask

    function automatic bit gen(input int l, input int i, input int seed);
        int v;
        v = l * 97 + i * 31 + seed;
        v = v ^ (v >> 3) ^ (i * l);
        return ^v[6:0];
    endfunction

    // monitor: scoreboard compare of frames and pass-through outputs
    always @(posedge clk) begin
        item_t it;
        #5;
        if (rst_n && !done) begin
            if (frm_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, $sformatf("R6 R8 unexpected frame act=1 exp=0 at edge %0d", edge_no));
                end else begin
                    it = q.pop_front();
                    chk(frm_data == it.data,
                        $sformatf("R3 R10 frame data act=%h exp=%h", frm_data, it.data));
                    chk(edge_no == it.due,
                        $sformatf("R4 frame edge act=%0d exp=%0d", edge_no, it.due));
                end
            end
            chk(pass_vld == (mode_resync ? '0 : lane_vld),
                $sformatf("R9 pass_vld act=%h exp=%h", pass_vld, mode_resync ? '0 : lane_vld));
            if (!mode_resync)
                chk(pass_bit == lane_bit,
                    $sformatf("R9 pass_bit act=%h exp=%h", pass_bit, lane_bit));
        end
    end

    // driver: trains, streams skewed lanes and queues expected frames
    task automatic run_scn(input int nfr, input bit resync, input bit exp_err, input int seed);
        int smax;
        int e0;
        item_t it;
        smax = 0;
        for (int l = 0; l < LANES; l++) if (sk[l] > smax) smax = sk[l];
        @(negedge clk);
        mode_resync = resync;
        train_req   = 1'b1;
        @(negedge clk);
        train_req = 1'b0;
        e0 = edge_no + 1;
        if (!exp_err && resync) begin
            for (int k = 0; k < nfr; k++) begin
                for (int l = 0; l < LANES; l++)
                    for (int b = 0; b < FUI; b++)
                        it.data[l*FUI + b] = gen(l, k*FUI + b, seed);
                it.due = e0 + smax + k*FUI + FUI;   // R4 due edge
                q.push_back(it);
            end
        end
        for (int t = 0; t < smax + nfr*FUI; t++) begin
            for (int l = 0; l < LANES; l++) begin
                int idx;
                idx = t - sk[l];
                lane_vld[l]  = (idx >= 0) && (idx < nfr*FUI);
                lane_bit[l]  = lane_vld[l] ? gen(l, idx, seed) : 1'b0;
                // R2: markers repeat on every frame start; only the first counts
                lane_mark[l] = lane_vld[l] && (idx % FUI == 0);
            end
            @(negedge clk);
        end
        lane_vld  = '0;
        lane_bit  = '0;
        lane_mark = '0;
        repeat (4) @(negedge clk);
        chk(q.size() == 0, $sformatf("R10 frames missing act=%0d exp=0", q.size()));
        chk(align_err == exp_err,
            $sformatf("%s align_err act=%0b exp=%0b", exp_err ? "R6" : "R5", align_err, exp_err));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(frm_valid == 1'b0, $sformatf("R1 frm_valid act=%0b exp=0", frm_valid));
        chk(align_err == 1'b0, $sformatf("R1 align_err act=%0b exp=0", align_err));
        chk(pass_vld == '0, $sformatf("R1 pass_vld act=%h exp=0", pass_vld));

        // R5 R3 R4 R2: wide skew including the 46-cycle limit
        sk = '{0, 46, 5, 12, 33, 20, 7, 40, 1, 28};
        run_scn(4, 1'b1, 1'b0, 3);

        // R3: all lanes in step
        sk = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0};
        run_scn(3, 1'b1, 1'b0, 11);

        // R6: one lane a cycle beyond the limit
        sk = '{0, 47, 3, 9, 14, 2, 30, 8, 21, 5};
        run_scn(2, 1'b1, 1'b1, 7);
        repeat (10) @(negedge clk);
        chk(align_err == 1'b1, $sformatf("R7 align_err held act=%0b exp=1", align_err));

        // R7: retraining with good skew recovers
        sk = '{17, 3, 0, 25, 9, 44, 12, 6, 38, 2};
        run_scn(3, 1'b1, 1'b0, 21);
        chk(align_err == 1'b0, $sformatf("R7 recovery align_err act=%0b exp=0", align_err));

        // R8 R9: resample mode forwards lanes, no frames
        sk = '{0, 46, 5, 12, 33, 20, 7, 40, 1, 28};
        run_scn(3, 1'b0, 1'b0, 5);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired act=running exp=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule